// File: doc/BRIEF.md
# Supply undervoltage reset generator

This block drives the active-low reset line of a microcontroller that draws its power from the local regulator. Its input is a digital comparator flag that is high while the regulated supply sits below its threshold. The flag is synchronised first. The block then declares an undervoltage only after the flag has stayed high for a debounce window. On that declaration it pulls reset low and sends a one-cycle event to the mode controller, which moves the device to standby.

When the supply comes back, reset is held low for a further extension window and then released. A dip during that extension window keeps reset low. The dip starts a new debounce, and the extension starts again from zero once the supply recovers. In sleep mode reset is forced low on the next clock edge, with no debounce, whatever the supply level. A reset-active flag lets the mode controller discard its pin inputs while reset is low.

The debounce window (`DEB_CYC`), the extension window (`EXT_CYC`) and the synchroniser depth (`SYNC_STAGES`) are all given in clock cycles. The analog comparator lies outside this block.

Top module: `uv_reset_gen`

## Requirements
- R1: While `rst` is high, `rstn` is 0, `rst_active` is 1 and `uv_event` is 0. After `rst` falls with `uv_below` low, `rstn` rises exactly SYNC_STAGES+1+EXT_CYC rising edges after the first edge at which `rst` is low.
- R2: Outside sleep, after the reset has been released, a `uv_below` held at 1 drives `rstn` to 0 exactly SYNC_STAGES+DEB_CYC edges after it rose. Until then `rstn` stays 1.
- R3: A `uv_below` pulse spanning only DEB_CYC-1 edges causes no reset and no event.
- R4: `uv_event` is a single-cycle pulse. It is high in the same cycle in which `rstn` first reads 0 for that undervoltage.
- R5: Once `uv_below` falls while reset is held for an undervoltage, `rstn` stays 0 for SYNC_STAGES+EXT_CYC edges and reads 1 after the next edge.
- R6: A dip shorter than DEB_CYC during the extension window keeps `rstn` at 0 and raises no event. `rstn` then rises exactly SYNC_STAGES+EXT_CYC edges after `uv_below` falls again.
- R7: A dip of DEB_CYC or more during the extension window raises a new `uv_event`, SYNC_STAGES+DEB_CYC edges after `uv_below` rose.
- R8: Mode encoding: 2'b00 sleep, 2'b01 standby, 2'b10 normal slope, 2'b11 low slope. One edge after `mode` becomes sleep, `rstn` is 0. In sleep the comparator is ignored and `uv_event` stays 0.
- R9: When `mode` leaves sleep with `uv_below` low, `rstn` rises exactly 2+EXT_CYC edges later.
- R10: `rst_active` is always the complement of `rstn`.
- R11: Standby, normal slope and low slope modes all apply the same debounce and extension timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| uv_below | input | 1 | Comparator flag, 1 = supply below threshold (asynchronous) |
| mode | input | 2 | Device mode (encoding in R8) |
| rstn | output | 1 | Active-low reset to the microcontroller |
| uv_event | output | 1 | One-cycle pulse: undervoltage declared, go to standby |
| rst_active | output | 1 | High while `rstn` is low |

## Verification
A debounce counter that misses a clear shows up as a reset fired by a short glitch. A counter that fails to clear between dips shows the same way. An off-by-one in either window moves the `rstn` edge by one cycle, so every edge is sampled at its exact expected cycle and on the cycle before it. If the state register failed to return to the extension state after a dip, reset would either come back too early or never be released. The dip-during-extension scenario exposes either fault within SYNC_STAGES+EXT_CYC cycles. A sleep path that was missing, or that went through the debounce, would leave `rstn` high one edge after sleep entry.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP    = 2'b00,
    MODE_STANDBY  = 2'b01,
    MODE_NORMAL   = 2'b10,
    MODE_LOWSLOPE = 2'b11
  } uvr_mode_e;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'b00,
    ST_EXTEND = 2'b01,
    ST_RUN    = 2'b10,
    ST_SLEEP  = 2'b11
  } uvr_state_e;
endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uvr_window_cnt.sv
module uvr_window_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // the window has elapsed on the LIMIT-th consecutive enabled cycle
  assign done = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/uv_reset_gen.sv
module uv_reset_gen #(
  parameter int DEB_CYC     = 250000,
  parameter int EXT_CYC     = 300000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uv_below,
  input  logic [1:0] mode,
  output logic       rstn,
  output logic       uv_event,
  output logic       rst_active
);
  import uvr_pkg::*;

  logic       uv_s;
  logic       is_sleep;
  logic       deb_en, deb_done;
  logic       ext_en, ext_done;
  uvr_state_e state_q, state_d;

  // reset value 1 treats the supply as low until the first samples arrive
  uvr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(uv_below), .q(uv_s)
  );

  assign is_sleep = (uvr_mode_e'(mode) == MODE_SLEEP);
  assign deb_en   = !is_sleep && uv_s &&
                    ((state_q == ST_RUN) || (state_q == ST_EXTEND));
  assign ext_en   = !is_sleep && !uv_s && (state_q == ST_EXTEND);

  uvr_window_cnt #(.LIMIT(DEB_CYC)) u_deb (
    .clk(clk), .rst(rst), .en(deb_en), .done(deb_done)
  );

  uvr_window_cnt #(.LIMIT(EXT_CYC)) u_ext (
    .clk(clk), .rst(rst), .en(ext_en), .done(ext_done)
  );

  always_comb begin
    state_d = state_q;
    if (is_sleep) begin
      state_d = ST_SLEEP;
    end else begin
      case (state_q)
        ST_SLEEP:  state_d = ST_HOLD;
        ST_HOLD:   if (!uv_s) state_d = ST_EXTEND;
        ST_EXTEND: if (deb_done)      state_d = ST_HOLD;
                   else if (ext_done) state_d = ST_RUN;
        ST_RUN:    if (deb_done) state_d = ST_HOLD;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HOLD;
      rstn       <= 1'b0;
      rst_active <= 1'b1;
      uv_event   <= 1'b0;
    end else begin
      state_q    <= state_d;
      rstn       <= (state_d == ST_RUN);
      rst_active <= (state_d != ST_RUN);
      uv_event   <= deb_done;
    end
  end

  AST_SLEEP_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    is_sleep |=> !rstn); // R8

  AST_NO_EVENT_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    is_sleep |=> !uv_event); // R8

  AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    uv_event |=> !uv_event); // R4

  AST_EVENT_WITH_LOW: assert property (@(posedge clk) disable iff (rst)
    uv_event |-> !rstn); // R4

  AST_RELEASE_GOOD_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $rose(rstn) |-> !$past(uv_s)); // R5

  AST_RELEASE_FROM_EXTEND: assert property (@(posedge clk) disable iff (rst)
    $rose(rstn) |-> ($past(state_q) == ST_EXTEND)); // R5
endmodule

// File: tb/uv_reset_gen_test.sv
`timescale 1ns/1ps
module uv_reset_gen_test;
  localparam int DEB  = 8;
  localparam int EXT  = 12;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       uv_below = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       rstn, uv_event, rst_active;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uv_reset_gen #(.DEB_CYC(DEB), .EXT_CYC(EXT), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .uv_below(uv_below), .mode(mode),
    .rstn(rstn), .uv_event(uv_event), .rst_active(rst_active)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rstn(input string tag, input logic exp);
    chk(rstn === exp, tag, int'(rstn), int'(exp));
    chk(rst_active === ~exp, {tag, " R10"}, int'(rst_active), int'(~exp));
  endtask

  task automatic t_por();
    rst = 1'b1; uv_below = 1'b0; mode = 2'b01;
    step(3);
    chk_rstn("R1 reset held", 1'b0);
    chk(uv_event === 1'b0, "R1 event in reset", int'(uv_event), 0);
    rst = 1'b0;
    step(SYNC + EXT);
    chk_rstn("R1 before release", 1'b0);
    step(1);
    chk_rstn("R1 release", 1'b1);
  endtask

  task automatic t_short_dip(input logic [1:0] m);
    mode = m;
    step(1);
    uv_below = 1'b1;
    step(DEB - 1);
    uv_below = 1'b0;
    for (int i = 0; i < SYNC + DEB + 3; i++) begin
      chk(rstn === 1'b1, "R3 short dip rstn", int'(rstn), 1);
      chk(uv_event === 1'b0, "R3 short dip event", int'(uv_event), 0);
      step(1);
    end
  endtask

  task automatic t_uv(input logic [1:0] m, input string tag);
    mode = m;
    step(1);
    uv_below = 1'b1;
    step(SYNC + DEB - 1);
    chk_rstn({tag, " R2 before declare"}, 1'b1);
    step(1);
    chk_rstn({tag, " R2 declare"}, 1'b0);
    chk(uv_event === 1'b1, {tag, " R4 event high"}, int'(uv_event), 1);
    step(1);
    chk(uv_event === 1'b0, {tag, " R4 event one cycle"}, int'(uv_event), 0);
    step(3);
    uv_below = 1'b0;
    step(SYNC + EXT);
    chk_rstn({tag, " R5 extension held"}, 1'b0);
    step(1);
    chk_rstn({tag, " R5 extension release"}, 1'b1);
  endtask

  task automatic enter_hold();
    uv_below = 1'b1;
    step(SYNC + DEB + 2);
    uv_below = 1'b0;
  endtask

  task automatic t_ext_dip();
    mode = 2'b01;
    enter_hold();
    step(SYNC + 1 + EXT / 2);
    uv_below = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk_rstn("R6 low during dip", 1'b0);
      step(1);
    end
    uv_below = 1'b0;
    for (int i = 0; i < SYNC + EXT - 1; i++) begin
      chk(rstn === 1'b0, "R6 held after dip", int'(rstn), 0);
      chk(uv_event === 1'b0, "R6 no event", int'(uv_event), 0);
      step(1);
    end
    chk_rstn("R6 still low", 1'b0);
    step(1);
    chk_rstn("R6 release restarted", 1'b1);
  endtask

  task automatic t_ext_long();
    mode = 2'b10;
    enter_hold();
    step(SYNC + 2);
    uv_below = 1'b1;
    step(SYNC + DEB - 1);
    chk(uv_event === 1'b0, "R7 before redeclare", int'(uv_event), 0);
    step(1);
    chk(uv_event === 1'b1, "R7 redeclare event", int'(uv_event), 1);
    chk_rstn("R7 low", 1'b0);
    uv_below = 1'b0;
    step(SYNC + EXT + 1);
    chk_rstn("R7 recovered", 1'b1);
  endtask

  task automatic t_sleep();
    uv_below = 1'b0;
    mode = 2'b00;
    step(1);
    chk_rstn("R8 sleep entry", 1'b0);
    uv_below = 1'b1;
    for (int i = 0; i < SYNC + DEB + 4; i++) begin
      chk(uv_event === 1'b0, "R8 no event in sleep", int'(uv_event), 0);
      step(1);
    end
    uv_below = 1'b0;
    step(5);
    chk_rstn("R8 still low", 1'b0);
    mode = 2'b01;
    step(1 + EXT);
    chk_rstn("R9 before release", 1'b0);
    step(1);
    chk_rstn("R9 release", 1'b1);
  endtask

  initial begin
    step(1);
    t_por();
    t_short_dip(2'b01);
    t_uv(2'b01, "R11 standby");
    t_uv(2'b10, "R11 normal");
    t_uv(2'b11, "R11 lowslope");
    t_short_dip(2'b11);
    t_ext_dip();
    t_ext_long();
    t_sleep();
    t_uv(2'b01, "R11 after sleep");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule